// File: doc/BRIEF.md
# Command/Response Bus Word Transmitter

This block drives one controller-to-terminal transfer onto a command/response serial bus. On a transfer request it builds a command word from the terminal address, subaddress and word count presented at its inputs and sends it. It then sends the requested number of data words back to back, taking each one from a small external buffer that it addresses in order. Every word lasts twenty bit times at 1 Mbps. Each word starts with a three-bit-time synchronisation waveform that is not valid Manchester data. Sixteen Manchester-coded bits follow, sent most significant bit first, and an odd parity bit closes the word.

The bit timing comes from a half-bit enable. A prescaler divides the 50 MHz system clock by 25, which gives 2 MHz, so each half-bit slot lasts 25 clocks. A single slot counter frames both word kinds. When the last data word has gone out, the line goes idle and the block stays busy until the receive side reports that the addressed terminal has returned its status word. Only then does it raise a one-cycle completion pulse and accept the next request.

Top module: `bcWordTx`

## Requirements
- R1: After reset, `lineOut`, `lineActive`, `busy` and `done` are all 0.
- R2: Each half-bit slot lasts DIV (25) clocks. A transfer of n data words keeps `lineActive` high for exactly (n+1)*40*DIV clocks, with no gap between words.
- R3: The sync field fills the first three bit times (six half-bit slots). In a command word the line is high for the first three slots and low for the next three. In a data word the order is reversed.
- R4: After the sync field come 16 bits, most significant first. A 1 is sent as high then low within its bit time, and a 0 as low then high.
- R5: The last bit time carries odd parity over the 16 word bits, encoded as in R4.
- R6: The command word holds the terminal address in bits 15:11, 0 (receive) in bit 10, the subaddress in bits 9:5 and the word count in bits 4:0.
- R7: The data words follow the command word. Their number equals the word count, and a count of 0 means 32. They are read from buffer addresses 0, 1, 2 and so on through `bufRdAddr`.
- R8: `busy` rises when a request is accepted. After the last word the line is idle (`lineActive`=0, `lineOut`=0) and `busy` stays high until `statusRcvd` is seen. The clock edge that sees `statusRcvd` drops `busy` and raises `done` for exactly one cycle.
- R9: While `busy` is high, `xferReq` is ignored. While words are still being sent, `statusRcvd` is ignored.
- R10: `lineOut` is 0 whenever `lineActive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz system clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferReq | input | 1 | Start a transfer (sampled while idle) |
| rtAddr | input | 5 | Terminal address for the command word |
| subAddr | input | 5 | Subaddress for the command word |
| wordCount | input | 5 | Data word count, 0 means 32 |
| bufRdData | input | 16 | Data word read from the buffer at `bufRdAddr` |
| statusRcvd | input | 1 | Pulse: status word from the terminal received |
| bufRdAddr | output | 5 | Buffer index of the next data word |
| lineOut | output | 1 | Encoded serial line level |
| lineActive | output | 1 | Line driver enable |
| busy | output | 1 | Transfer in progress or awaiting status |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
Some properties are checked on every cycle. The line stays low whenever its driver is off. The slot counter holds between half-bit enables. The parity half-slot makes the word's ones count odd. A command load is followed by the command sync polarity. The sending state never drops straight back to idle. Completion pulses only come straight after the status wait. Other behaviour shows only at the ports and is left to the bench scenarios: the exact waveform of each half-bit against a scoreboard of expected levels, the total active time for a given word count, the wrap of a zero count to 32 words, the buffer read order, and whether stray requests and status pulses are ignored in the middle of a transfer.

// File: rtl/bcTxPkg.sv
package bcTxPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic loadData;
    logic sending;
  } txStrobe_t;

endpackage

// File: rtl/bcTxCtrl.sv
module bcTxCtrl
  import bcTxPkg::*;
#(
  parameter int DIV     = 25,
  parameter int SLOTS   = 40,
  parameter int SLOT_W  = 6,
  parameter int FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xferReq,
  input  logic [FIELD_W-1:0] wordCount,
  input  logic               statusRcvd,
  output txStrobe_t          strb,
  output logic [SLOT_W-1:0]  slot,
  output logic               busy,
  output logic               done
);

  localparam int DIV_W     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int REM_W     = FIELD_W + 1;
  localparam int MAX_WORDS = 1 << FIELD_W;

  txState_t           state;
  logic [DIV_W-1:0]   divCnt;
  logic [REM_W-1:0]   remain;
  logic [REM_W-1:0]   wcEff;
  logic               tick;
  logic               lastSlot;
  logic               doneQ;

  assign tick     = (state == ST_SEND) && (divCnt == DIV_W'(DIV - 1));
  assign lastSlot = (slot == SLOT_W'(SLOTS - 1));
  assign wcEff    = (wordCount == '0) ? REM_W'(MAX_WORDS) : {1'b0, wordCount};

  always_comb begin
    strb          = '0;
    strb.loadCmd  = (state == ST_IDLE) && xferReq;
    strb.loadData = tick && lastSlot && (remain != '0);
    strb.sending  = (state == ST_SEND);
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      slot   <= '0;
      remain <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= (state == ST_WAIT) && statusRcvd;
      case (state)
        ST_IDLE: begin
          if (xferReq) begin
            state  <= ST_SEND;
            divCnt <= '0;
            slot   <= '0;
            remain <= wcEff;
          end
        end
        ST_SEND: begin
          if (tick) begin
            divCnt <= '0;
            if (lastSlot) begin
              slot <= '0;
              if (remain != '0) remain <= remain - 1'b1;
              else              state  <= ST_WAIT;
            end else begin
              slot <= slot + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (statusRcvd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the slot index only moves on a half-bit enable
  a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && divCnt != DIV_W'(DIV - 1)) |=> $stable(slot));

  // R8: sending never returns straight to idle; status wait always follows
  a_r8_send_to_wait: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |=> (state != ST_IDLE));

  // R8: completion pulse only right after the status wait
  a_r8_done_after_wait: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> ($past(state == ST_WAIT) && state == ST_IDLE));

endmodule

// File: rtl/bcTxDatapath.sv
module bcTxDatapath
  import bcTxPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5,
  parameter int SLOTS   = 40,
  parameter int SLOT_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          strb,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [FIELD_W-1:0] rtAddr,
  input  logic [FIELD_W-1:0] subAddr,
  input  logic [FIELD_W-1:0] wordCount,
  input  logic [DATA_W-1:0]  bufRdData,
  output logic [FIELD_W-1:0] bufRdAddr,
  output logic               lineOut,
  output logic               lineActive
);

  localparam int SYNC_HALF  = 3;
  localparam int SYNC_SLOTS = 2 * SYNC_HALF;
  localparam int PAR_SLOT   = SYNC_SLOTS + 2 * DATA_W;

  logic [DATA_W-1:0]  wordReg;
  logic               isData;
  logic [FIELD_W-1:0] dataIdx;
  logic [DATA_W-1:0]  cmdWord;
  logic               parityBit;
  logic               level;
  logic               lineOutQ;
  logic               lineActiveQ;

  // command layout: address, receive flag (0), subaddress, count
  assign cmdWord   = DATA_W'({rtAddr, 1'b0, subAddr, wordCount});
  assign parityBit = ~(^wordReg);
  assign bufRdAddr = dataIdx;

  always_comb begin
    int  rel;
    int  bp;
    logic bitVal;
    rel    = int'(slot) - SYNC_SLOTS;
    bp     = (rel >= 0) ? (rel >> 1) : 0;
    bitVal = 1'b0;
    if (int'(slot) < SYNC_HALF) begin
      level = ~isData;
    end else if (int'(slot) < SYNC_SLOTS) begin
      level = isData;
    end else begin
      if (bp < DATA_W) bitVal = wordReg[DATA_W-1-bp];
      else             bitVal = parityBit;
      level = rel[0] ? ~bitVal : bitVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg     <= '0;
      isData      <= 1'b0;
      dataIdx     <= '0;
      lineOutQ    <= 1'b0;
      lineActiveQ <= 1'b0;
    end else begin
      if (strb.loadCmd) begin
        wordReg <= cmdWord;
        isData  <= 1'b0;
        dataIdx <= '0;
      end else if (strb.loadData) begin
        wordReg <= bufRdData;
        isData  <= 1'b1;
        dataIdx <= dataIdx + 1'b1;
      end
      lineOutQ    <= strb.sending & level;
      lineActiveQ <= strb.sending;
    end
  end

  assign lineOut    = lineOutQ;
  assign lineActive = lineActiveQ;

  // R10: a released line is held low
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !lineActiveQ |-> !lineOutQ);

  // R3: a freshly loaded command word carries the command sync polarity
  a_r3_cmd_sync: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCmd |=> !isData);

  // R5: during the parity half-slot the ones count of word plus line is odd
  a_r5_odd_parity: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sending && slot == SLOT_W'(PAR_SLOT) &&
     $past(strb.sending && slot == SLOT_W'(PAR_SLOT)))
    |-> (($countones({wordReg, lineOutQ}) & 1) == 1));

endmodule

// File: rtl/bcWordTx.sv
module bcWordTx
  import bcTxPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5,
  parameter int DIV     = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               xferReq,
  input  logic [FIELD_W-1:0] rtAddr,
  input  logic [FIELD_W-1:0] subAddr,
  input  logic [FIELD_W-1:0] wordCount,
  input  logic [DATA_W-1:0]  bufRdData,
  input  logic               statusRcvd,
  output logic [FIELD_W-1:0] bufRdAddr,
  output logic               lineOut,
  output logic               lineActive,
  output logic               busy,
  output logic               done
);

  localparam int SLOTS  = 2 * (DATA_W + 4);
  localparam int SLOT_W = $clog2(SLOTS);

  txStrobe_t         strb;
  logic [SLOT_W-1:0] slot;

  bcTxCtrl #(
    .DIV(DIV), .SLOTS(SLOTS), .SLOT_W(SLOT_W), .FIELD_W(FIELD_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .wordCount(wordCount),
    .statusRcvd(statusRcvd), .strb(strb), .slot(slot),
    .busy(busy), .done(done)
  );

  bcTxDatapath #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .slot(slot),
    .rtAddr(rtAddr), .subAddr(subAddr), .wordCount(wordCount),
    .bufRdData(bufRdData), .bufRdAddr(bufRdAddr),
    .lineOut(lineOut), .lineActive(lineActive)
  );

endmodule

// File: tb/tb_bcWordTx.sv
module tb_bcWordTx;

  localparam int CLK_PERIOD = 20;
  localparam int DIV        = 25;
  localparam int SLOTS      = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferReq = 1'b0;
  logic [4:0]  rtAddr = '0;
  logic [4:0]  subAddr = '0;
  logic [4:0]  wordCount = '0;
  logic [15:0] bufRdData;
  logic        statusRcvd = 1'b0;
  logic [4:0]  bufRdAddr;
  logic        lineOut, lineActive, busy, done;

  logic [15:0] bufMem [32];
  assign bufRdData = bufMem[bufRdAddr];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  bit    expLvl[$];
  string expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcWordTx dut (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .rtAddr(rtAddr),
    .subAddr(subAddr), .wordCount(wordCount), .bufRdData(bufRdData),
    .statusRcvd(statusRcvd), .bufRdAddr(bufRdAddr), .lineOut(lineOut),
    .lineActive(lineActive), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver side: expected half-bit levels of one word
  task automatic pushWord(input bit isDataWord, input logic [15:0] w);
    bit p;
    for (int i = 0; i < 3; i++) begin expLvl.push_back(~isDataWord); expTag.push_back("R3"); end
    for (int i = 0; i < 3; i++) begin expLvl.push_back(isDataWord);  expTag.push_back("R3"); end
    for (int b = 15; b >= 0; b--) begin
      expLvl.push_back(w[b]);  expTag.push_back("R4");
      expLvl.push_back(~w[b]); expTag.push_back("R4");
    end
    p = ~(^w);
    expLvl.push_back(p);  expTag.push_back("R5");
    expLvl.push_back(~p); expTag.push_back("R5");
  endtask

  // monitor: sample the line in the middle of each half-bit slot
  initial begin
    forever begin
      @(posedge lineActive);
      if (expLvl.size() == 0) begin
        check(1'b0, "R9", "line started with no transfer requested", 1, 0);
      end else begin
        repeat (12) @(posedge clk);
        @(negedge clk);
        while (expLvl.size() > 0) begin
          bit    lvl;
          string tg;
          lvl = expLvl.pop_front();
          tg  = expTag.pop_front();
          check(lineActive === 1'b1 && lineOut === lvl, tg,
                "half-bit level", int'(lineOut), int'(lvl));
          if (expLvl.size() > 0) repeat (DIV) @(negedge clk);
        end
      end
    end
  end

  task automatic runXfer(input logic [4:0] rt, input logic [4:0] sa,
                         input logic [4:0] wc, input bit disturb);
    int n;
    int cyc;
    n = (wc == 0) ? 32 : int'(wc);
    pushWord(1'b0, {rt, 1'b0, sa, wc});      // R6 command layout
    for (int i = 0; i < n; i++) pushWord(1'b1, bufMem[i]);  // R7 order
    @(negedge clk);
    rtAddr = rt; subAddr = sa; wordCount = wc; xferReq = 1'b1;
    @(negedge clk);
    xferReq = 1'b0;
    check(busy === 1'b1, "R8", "busy after accept", int'(busy), 1);
    cyc = 0;
    @(negedge clk);
    while (lineActive === 1'b1) begin
      cyc++;
      if (disturb && cyc == 400) begin
        statusRcvd = 1'b1; xferReq = 1'b1; rtAddr = ~rt; wordCount = wc + 5'd1;
      end
      if (disturb && cyc == 401) begin
        statusRcvd = 1'b0; xferReq = 1'b0;
      end
      @(negedge clk);
    end
    check(cyc == (n + 1) * SLOTS * DIV, "R2", "active clocks", cyc, (n + 1) * SLOTS * DIV);
    check(expLvl.size() == 0, "R7", "half-bits left unsent", expLvl.size(), 0);
    expLvl.delete(); expTag.delete();
    repeat (5) @(negedge clk);
    check(lineOut === 1'b0, "R10", "line low while released", int'(lineOut), 0);
    check(busy === 1'b1, "R8", "busy held awaiting status", int'(busy), 1);
    if (disturb) check(busy === 1'b1, "R9", "status during send ignored", int'(busy), 1);
    // R9: request while awaiting status is ignored
    xferReq = 1'b1;
    @(negedge clk);
    xferReq = 1'b0;
    repeat (30) @(negedge clk);
    check(lineActive === 1'b0, "R9", "request ignored while busy", int'(lineActive), 0);
    check(done === 1'b0, "R8", "no done before status", int'(done), 0);
    statusRcvd = 1'b1;
    @(negedge clk);
    statusRcvd = 1'b0;
    check(done === 1'b1, "R8", "done pulse", int'(done), 1);
    check(busy === 1'b0, "R8", "busy cleared", int'(busy), 0);
    @(negedge clk);
    check(done === 1'b0, "R8", "done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) bufMem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(lineOut === 1'b0, "R1", "lineOut after reset", int'(lineOut), 0);
    check(lineActive === 1'b0, "R1", "lineActive after reset", int'(lineActive), 0);
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(done === 1'b0, "R1", "done after reset", int'(done), 0);

    bufMem[0] = 16'h4142; bufMem[1] = 16'h4142;
    runXfer(5'h15, 5'h03, 5'd2, 1'b0);

    bufMem[0] = 16'hFFFF; bufMem[1] = 16'h0000; bufMem[2] = 16'h8001;
    runXfer(5'h1F, 5'h00, 5'd3, 1'b1);

    for (int i = 0; i < 32; i++) bufMem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    runXfer(5'h00, 5'h1F, 5'd0, 1'b0);   // R7: count 0 sends 32 words

    bufMem[0] = 16'h7FFE;
    runXfer(5'h0A, 5'h15, 5'd1, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule